// File: doc/BRIEF.md
# Register Window Control Unit

This block tracks the bookkeeping for a windowed integer register file with `NWIN` windows. It holds the current window pointer, four window counters (windows free to save into, windows free to restore from, windows known to be clean, and windows owned by another context) and a six-bit trap-vector state register. A pipeline issues one operation per cycle, either a save, a restore or a flush of all windows. The unit then moves the pointer, adjusts the counters and, when the window file cannot satisfy the request, raises a spill, fill or clean-window trap. Spill and fill traps carry a three-bit vector choice and a flag that marks the vector as coming from the other-context half of the state register.

Every register can also be loaded through a small configuration write port, so that trap handlers and start-up code can set up the window state. All updates take effect at the rising clock edge. The trap outputs are registered and appear in the cycle after the operation.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the free-to-save count is NWIN-2, the free-to-restore count is 0, the clean count is NWIN-1, the other-context count is 0, the trap-vector state is 0 and no trap is signalled.
- R2: A save (op code 0) with a free-to-save count of 0 raises a spill trap and advances the pointer by two modulo NWIN. Both counts stay unchanged.
- R3: A save with a nonzero free-to-save count and a clean count equal to the free-to-restore count raises a clean-window trap (vector 0, other flag 0). It advances the pointer by one modulo NWIN and leaves the counts unchanged.
- R4: Any other save advances the pointer by one modulo NWIN, lowers the free-to-save count by one, raises the free-to-restore count by one and signals no trap.
- R5: A restore (op code 1) always moves the pointer back by one modulo NWIN, whether or not a trap fires; from 0 it moves to NWIN-1.
- R6: A restore with a free-to-restore count of 0 raises a fill trap and leaves the counts unchanged. Otherwise it raises the free-to-save count by one and lowers the free-to-restore count by one, with no trap.
- R7: A flush (op code 2) raises a spill trap exactly when NWIN-2 minus the free-to-save count is 0. Otherwise it signals no trap. It never changes the pointer or the counts.
- R8: For spill and fill traps the other flag is 1 when the other-context count is nonzero. The vector is then state bits [5:3]; when the count is zero the vector is state bits [2:0].
- R9: The trap outputs are registered. The valid output is high only in the cycle after a trapping operation. The kind is encoded 1 for spill, 2 for fill and 3 for clean-window. A cycle with no operation gives no trap in the next cycle.
- R10: Configuration writes use these addresses: 0 for the pointer, 1 for free-to-save, 2 for free-to-restore, 3 for clean, 4 for other-context and 5 for trap-vector state; addresses 6 and 7 change nothing. A write in a cycle with an operation request is ignored. A pointer write of NWIN or more is ignored.
- R11: A request with op code 3 changes no register and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_kind | input | 2 | 0 save, 1 restore, 2 flush, 3 no operation |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CFG_W (6) | Configuration write data |
| cwp | output | CWP_W (5) | Current window pointer |
| cansave | output | CNT_W (5) | Windows free to save into |
| canrestore | output | CNT_W (5) | Windows free to restore from |
| cleanwin | output | CNT_W (5) | Clean window count |
| otherwin | output | CNT_W (5) | Windows owned by another context |
| wstate | output | WS_W (6) | Trap-vector state |
| trap_valid | output | 1 | Trap raised by the previous cycle's operation |
| trap_kind | output | 2 | 1 spill, 2 fill, 3 clean-window |
| trap_type | output | WS_W/2 (3) | Selected trap vector |
| trap_other | output | 1 | Vector taken from the other-context half |

## Verification
The bound checker watches the relationships that hold on every cycle. These are the pointer staying below NWIN, the pointer step taken by each accepted save and restore, unchanged counts on spill, fill and clean traps and on flushes, the choice of vector half behind every spill or fill, and the absence of a trap after an idle cycle. Only the directed scenarios can show the specific values. These include the reset contents, the pointer wrapping past NWIN-1 and below 0, the exact flush threshold at NWIN-2, and the configuration port ignoring out-of-range pointers, unused addresses and writes that collide with an operation.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_FLUSH   = 2'd2,
    OP_NONE    = 2'd3
  } rw_op_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_SPILL = 2'd1,
    TK_FILL  = 2'd2,
    TK_CLEAN = 2'd3
  } rw_trap_e;

  typedef enum logic [2:0] {
    CA_CWP     = 3'd0,
    CA_CANSAVE = 3'd1,
    CA_CANREST = 3'd2,
    CA_CLEAN   = 3'd3,
    CA_OTHER   = 3'd4,
    CA_WSTATE  = 3'd5
  } rw_cfg_e;

  // Forward step on a ring of n entries; cur < n and step < n assumed.
  function automatic int ring_fwd(input int cur, input int step, input int n);
    int s;
    s = cur + step;
    return (s >= n) ? (s - n) : s;
  endfunction

  // One step backward on a ring of n entries.
  function automatic int ring_back(input int cur, input int n);
    return (cur == 0) ? (n - 1) : (cur - 1);
  endfunction

  // Free-to-save headroom left before a flush must spill.
  function automatic int flush_room(input int n, input int cansave_v);
    return n - 2 - cansave_v;
  endfunction

endpackage

// File: rtl/rw_window_eval.sv
module rw_window_eval
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CNT_W = 5
) (
  input  logic             acc_save,
  input  logic             acc_restore,
  input  logic             acc_flush,
  input  logic [CNT_W-1:0] cansave,
  input  logic [CNT_W-1:0] canrestore,
  input  logic [CNT_W-1:0] cleanwin,
  output rw_trap_e         kind,
  output logic [CNT_W-1:0] cansave_nxt,
  output logic [CNT_W-1:0] canrestore_nxt
);

  logic save_blocked;
  logic clean_hit;
  logic restore_blocked;
  logic flush_full;

  assign save_blocked    = (cansave == '0);
  assign clean_hit       = (cleanwin == canrestore);
  assign restore_blocked = (canrestore == '0);
  assign flush_full      = (flush_room(NWIN, int'(cansave)) == 0);

  always_comb begin
    kind           = TK_NONE;
    cansave_nxt    = cansave;
    canrestore_nxt = canrestore;
    if (acc_save) begin
      if (save_blocked) begin
        kind = TK_SPILL;
      end else if (clean_hit) begin
        kind = TK_CLEAN;
      end else begin
        cansave_nxt    = cansave - 1'b1;
        canrestore_nxt = canrestore + 1'b1;
      end
    end else if (acc_restore) begin
      if (restore_blocked) begin
        kind = TK_FILL;
      end else begin
        cansave_nxt    = cansave + 1'b1;
        canrestore_nxt = canrestore - 1'b1;
      end
    end else if (acc_flush) begin
      if (flush_full) kind = TK_SPILL;
    end
  end

endmodule

// File: rtl/rw_ptr_step.sv
module rw_ptr_step
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = 5
) (
  input  logic             acc_save,
  input  logic             acc_restore,
  input  rw_trap_e         kind,
  input  logic [CWP_W-1:0] cwp,
  output logic [CWP_W-1:0] cwp_nxt
);

  logic [CWP_W-1:0] fwd_one;
  logic [CWP_W-1:0] fwd_two;
  logic [CWP_W-1:0] back_one;

  assign fwd_one  = CWP_W'(ring_fwd(int'(cwp), 1, NWIN));
  assign fwd_two  = CWP_W'(ring_fwd(int'(cwp), 2, NWIN));
  assign back_one = CWP_W'(ring_back(int'(cwp), NWIN));

  always_comb begin
    cwp_nxt = cwp;
    if (acc_save) begin
      cwp_nxt = (kind == TK_SPILL) ? fwd_two : fwd_one;
    end else if (acc_restore) begin
      cwp_nxt = back_one;
    end
  end

endmodule

// File: rtl/rw_trap_fmt.sv
module rw_trap_fmt
  import rwin_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int WS_W  = 6
) (
  input  rw_trap_e            kind,
  input  logic [CNT_W-1:0]    otherwin,
  input  logic [WS_W-1:0]     wstate,
  output logic [WS_W/2-1:0]   vec,
  output logic                other
);

  localparam int HALF = WS_W / 2;

  logic uses_state;
  logic from_other;

  assign uses_state = (kind == TK_SPILL) || (kind == TK_FILL);
  assign from_other = (otherwin != '0);

  always_comb begin
    vec   = '0;
    other = 1'b0;
    if (uses_state) begin
      other = from_other;
      vec   = from_other ? wstate[WS_W-1:HALF] : wstate[HALF-1:0];
    end
  end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = 5,
  parameter int CNT_W = 5,
  parameter int WS_W  = 6,
  parameter int CFG_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CWP_W-1:0]   cwp,
  output logic [CNT_W-1:0]   cansave,
  output logic [CNT_W-1:0]   canrestore,
  output logic [CNT_W-1:0]   cleanwin,
  output logic [CNT_W-1:0]   otherwin,
  output logic [WS_W-1:0]    wstate,
  output logic               trap_valid,
  output logic [1:0]         trap_kind,
  output logic [WS_W/2-1:0]  trap_type,
  output logic               trap_other
);

  localparam int HALF = WS_W / 2;
  localparam logic [CNT_W-1:0] RST_CANSAVE = CNT_W'(NWIN - 2);
  localparam logic [CNT_W-1:0] RST_CLEAN   = CNT_W'(NWIN - 1);

  // Named events used by the checker
  logic acc_save;
  logic acc_restore;
  logic acc_flush;
  logic acc_cfg;
  logic cwp_wr_ok;

  assign acc_save    = op_valid && (op_kind == 2'(OP_SAVE));
  assign acc_restore = op_valid && (op_kind == 2'(OP_RESTORE));
  assign acc_flush   = op_valid && (op_kind == 2'(OP_FLUSH));
  assign acc_cfg     = cfg_we && !op_valid;
  assign cwp_wr_ok   = (int'(cfg_wdata) < NWIN);

  rw_trap_e         kind;
  logic [CNT_W-1:0] cansave_nxt;
  logic [CNT_W-1:0] canrestore_nxt;
  logic [CWP_W-1:0] cwp_nxt;
  logic [HALF-1:0]  vec;
  logic             other;

  rw_window_eval #(.NWIN(NWIN), .CNT_W(CNT_W)) u_eval (
    .acc_save       (acc_save),
    .acc_restore    (acc_restore),
    .acc_flush      (acc_flush),
    .cansave        (cansave),
    .canrestore     (canrestore),
    .cleanwin       (cleanwin),
    .kind           (kind),
    .cansave_nxt    (cansave_nxt),
    .canrestore_nxt (canrestore_nxt)
  );

  rw_ptr_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ptr (
    .acc_save    (acc_save),
    .acc_restore (acc_restore),
    .kind        (kind),
    .cwp         (cwp),
    .cwp_nxt     (cwp_nxt)
  );

  rw_trap_fmt #(.CNT_W(CNT_W), .WS_W(WS_W)) u_fmt (
    .kind     (kind),
    .otherwin (otherwin),
    .wstate   (wstate),
    .vec      (vec),
    .other    (other)
  );

  // Window state registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp        <= '0;
      cansave    <= RST_CANSAVE;
      canrestore <= '0;
      cleanwin   <= RST_CLEAN;
      otherwin   <= '0;
      wstate     <= '0;
    end else if (acc_cfg) begin
      case (cfg_addr)
        3'(CA_CWP):     if (cwp_wr_ok) cwp <= cfg_wdata[CWP_W-1:0];
        3'(CA_CANSAVE): cansave    <= cfg_wdata[CNT_W-1:0];
        3'(CA_CANREST): canrestore <= cfg_wdata[CNT_W-1:0];
        3'(CA_CLEAN):   cleanwin   <= cfg_wdata[CNT_W-1:0];
        3'(CA_OTHER):   otherwin   <= cfg_wdata[CNT_W-1:0];
        3'(CA_WSTATE):  wstate     <= cfg_wdata[WS_W-1:0];
        default: ;
      endcase
    end else begin
      cwp        <= cwp_nxt;
      cansave    <= cansave_nxt;
      canrestore <= canrestore_nxt;
    end
  end

  // Trap outputs, one cycle after the operation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_kind  <= 2'(TK_NONE);
      trap_type  <= '0;
      trap_other <= 1'b0;
    end else begin
      trap_valid <= (kind != TK_NONE);
      trap_kind  <= 2'(kind);
      trap_type  <= vec;
      trap_other <= other;
    end
  end

endmodule

// File: rtl/rwin_ctrl_chk.sv
module rwin_ctrl_chk #(
  parameter int NWIN  = 8,
  parameter int CWP_W = 5,
  parameter int CNT_W = 5,
  parameter int WS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              acc_save,
  input logic              acc_restore,
  input logic              acc_flush,
  input logic [CWP_W-1:0]  cwp,
  input logic [CNT_W-1:0]  cansave,
  input logic [CNT_W-1:0]  canrestore,
  input logic [CNT_W-1:0]  cleanwin,
  input logic [CNT_W-1:0]  otherwin,
  input logic [WS_W-1:0]   wstate,
  input logic              trap_valid,
  input logic [1:0]        trap_kind,
  input logic [WS_W/2-1:0] trap_type,
  input logic              trap_other
);

  localparam int HALF = WS_W / 2;

  // R10: the pointer never leaves the ring
  a_r10_cwp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);

  a_r2_spill_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    acc_save && cansave == '0 |=>
      trap_kind == 2'd1 && int'(cwp) == (int'($past(cwp)) + 2) % NWIN
      && $stable(cansave) && $stable(canrestore));

  a_r3_clean_keeps_counts: assert property (@(posedge clk) disable iff (!rst_n)
    acc_save && cansave != '0 && cleanwin == canrestore |=>
      trap_kind == 2'd3 && trap_valid && $stable(cansave) && $stable(canrestore)
      && int'(cwp) == (int'($past(cwp)) + 1) % NWIN);

  a_r4_save_moves_counts: assert property (@(posedge clk) disable iff (!rst_n)
    acc_save && cansave != '0 && cleanwin != canrestore |=>
      !trap_valid && cansave == $past(cansave) - 1'b1
      && canrestore == $past(canrestore) + 1'b1);

  a_r5_restore_steps_back: assert property (@(posedge clk) disable iff (!rst_n)
    acc_restore |=>
      int'(cwp) == (($past(cwp) == '0) ? NWIN - 1 : int'($past(cwp)) - 1));

  a_r6_fill_keeps_counts: assert property (@(posedge clk) disable iff (!rst_n)
    acc_restore && canrestore == '0 |=>
      trap_valid && trap_kind == 2'd2 && $stable(cansave) && $stable(canrestore));

  a_r7_flush_no_motion: assert property (@(posedge clk) disable iff (!rst_n)
    acc_flush |=> $stable(cwp) && $stable(cansave) && $stable(canrestore));

  a_r8_vector_half: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && (trap_kind == 2'd1 || trap_kind == 2'd2) |->
      trap_other == (otherwin != '0)
      && trap_type == ((otherwin != '0) ? wstate[WS_W-1:HALF] : wstate[HALF-1:0]));

  a_r9_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !trap_valid);

endmodule

bind rwin_ctrl rwin_ctrl_chk #(
  .NWIN(NWIN), .CWP_W(CWP_W), .CNT_W(CNT_W), .WS_W(WS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .acc_save    (acc_save),
  .acc_restore (acc_restore),
  .acc_flush   (acc_flush),
  .cwp         (cwp),
  .cansave     (cansave),
  .canrestore  (canrestore),
  .cleanwin    (cleanwin),
  .otherwin    (otherwin),
  .wstate      (wstate),
  .trap_valid  (trap_valid),
  .trap_kind   (trap_kind),
  .trap_type   (trap_type),
  .trap_other  (trap_other)
);

// File: tb/sim_rwin_ctrl.sv
`timescale 1ns/1ps
module sim_rwin_ctrl;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'd3;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [5:0] cfg_wdata = 6'd0;
  logic [4:0] cwp, cansave, canrestore, cleanwin, otherwin;
  logic [5:0] wstate;
  logic       trap_valid, trap_other;
  logic [1:0] trap_kind;
  logic [2:0] trap_type;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rwin_ctrl #(.NWIN(N)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate),
    .trap_valid(trap_valid), .trap_kind(trap_kind),
    .trap_type(trap_type), .trap_other(trap_other)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] k);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k;
    @(negedge clk);
    op_valid = 1'b0; op_kind = 2'd3;
  endtask

  task automatic do_cfg(input logic [2:0] a, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cwp", cwp, 0);
    chk("R1 cansave", cansave, N - 2);
    chk("R1 canrestore", canrestore, 0);
    chk("R1 cleanwin", cleanwin, N - 1);
    chk("R1 otherwin", otherwin, 0);
    chk("R1 wstate", wstate, 0);
    chk("R1 trap_valid", trap_valid, 0);
  endtask

  task automatic t_save_ok();
    do_op(2'd0);
    chk("R4 cwp", cwp, 1);
    chk("R4 cansave", cansave, N - 3);
    chk("R4 canrestore", canrestore, 1);
    chk("R4 no trap", trap_valid, 0);
  endtask

  task automatic t_clean();
    do_cfg(3'd3, 6'd1);
    do_op(2'd0);
    chk("R3 valid", trap_valid, 1);
    chk("R3 kind", trap_kind, 3);
    chk("R3 type", trap_type, 0);
    chk("R3 other", trap_other, 0);
    chk("R3 cwp", cwp, 2);
    chk("R3 cansave", cansave, N - 3);
    chk("R3 canrestore", canrestore, 1);
    @(negedge clk);
    chk("R9 pulse ends", trap_valid, 0);
  endtask

  task automatic t_spill();
    do_cfg(3'd1, 6'd0);
    do_cfg(3'd5, 6'b101011);
    do_op(2'd0);
    chk("R2 kind", trap_kind, 1);
    chk("R2 cwp", cwp, 4);
    chk("R2 cansave", cansave, 0);
    chk("R2 canrestore", canrestore, 1);
    chk("R8 type normal", trap_type, 3);
    chk("R8 other normal", trap_other, 0);
    do_cfg(3'd4, 6'd2);
    do_op(2'd0);
    chk("R2 cwp second", cwp, 6);
    chk("R8 type other", trap_type, 5);
    chk("R8 other flag", trap_other, 1);
    do_op(2'd0);
    chk("R2 cwp wrap", cwp, (6 + 2) % N);
  endtask

  task automatic t_restore();
    do_cfg(3'd2, 6'd0);
    do_op(2'd1);
    chk("R6 fill kind", trap_kind, 2);
    chk("R6 fill valid", trap_valid, 1);
    chk("R5 cwp wrap back", cwp, N - 1);
    chk("R6 cansave kept", cansave, 0);
    chk("R6 canrestore kept", canrestore, 0);
    chk("R8 fill type", trap_type, 5);
    do_cfg(3'd1, 6'd2);
    do_cfg(3'd2, 6'd3);
    do_cfg(3'd4, 6'd0);
    do_op(2'd1);
    chk("R6 no trap", trap_valid, 0);
    chk("R5 cwp", cwp, N - 2);
    chk("R6 cansave", cansave, 3);
    chk("R6 canrestore", canrestore, 2);
  endtask

  task automatic t_flush();
    do_cfg(3'd1, 6'(N - 2));
    do_op(2'd2);
    chk("R7 spill valid", trap_valid, 1);
    chk("R7 spill kind", trap_kind, 1);
    chk("R8 flush type", trap_type, 3);
    chk("R7 cwp kept", cwp, N - 2);
    chk("R7 cansave kept", cansave, N - 2);
    do_cfg(3'd1, 6'd3);
    do_op(2'd2);
    chk("R7 no trap", trap_valid, 0);
    chk("R7 cwp kept 2", cwp, N - 2);
    chk("R7 cansave kept 2", cansave, 3);
  endtask

  task automatic t_cfg();
    do_cfg(3'd0, 6'(N));
    chk("R10 big cwp ignored", cwp, N - 2);
    do_cfg(3'd0, 6'd5);
    chk("R10 cwp write", cwp, 5);
    do_cfg(3'd6, 6'h1f);
    chk("R10 addr6 cwp", cwp, 5);
    chk("R10 addr6 cansave", cansave, 3);
    chk("R10 addr6 cleanwin", cleanwin, 1);
    chk("R10 addr6 wstate", wstate, 6'b101011);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'd3;
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 6'd2;
    @(negedge clk);
    op_valid = 1'b0; cfg_we = 1'b0;
    chk("R10 write with op ignored", cwp, 5);
    chk("R11 reserved no trap", trap_valid, 0);
    chk("R11 reserved cansave", cansave, 3);
    chk("R11 reserved canrestore", canrestore, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_save_ok();
    t_clean();
    t_spill();
    t_restore();
    t_flush();
    t_cfg();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule